// File: doc/BRIEF.md
# BCD Calendar Timekeeper with Alarm

This block is a real-time clock core. A one-cycle enable, pulsed once per second by a divider outside the block, moves a chain of packed-BCD counters forward: seconds, minutes, hours, day of month, month, two-digit year and weekday. The day counter rolls over at the end of each month, and the month length depends on the calendar. February gains a 29th day when the two-digit year is a multiple of four. The year field holds 00 to 99 and covers the years 2000 to 2099.

Software or a controlling state machine drives the run input low to stop the clock. While the clock is stopped, one load strobe writes every time field in a single cycle. Raising run again restarts counting. Four pulse outputs mark each second, minute, hour and day boundary. A separate alarm pulse fires when the time reached on a tick equals all six alarm fields. The weekday takes no part in the alarm comparison. All results are registered and appear together with the updated counter values.

Top module: `bcd_calendar_rtc`

## Requirements
- R1: After reset, the outputs read 00 seconds, 00 minutes, 00 hours, day 01, month 01, year 00 and weekday 0, and all five pulse outputs are low.
- R2: Each tick taken while running adds one to the seconds in packed BCD, with a decimal carry into the tens nibble (for example 0x09 becomes 0x10).
- R3: Seconds wrap from 0x59 to 0x00 and carry into the minutes. Minutes wrap from 0x59 to 0x00 and carry into the hours. Hours wrap from 0x23 to 0x00 and carry into the day.
- R4: `evt_sec` pulses for one cycle on every tick that advances the clock. `evt_min`, `evt_hour` and `evt_day` pulse on the ticks that wrap the seconds, minutes and hours fields. Every pulse appears in the same cycle as the updated fields.
- R5: The day of month wraps to 0x01 after day 0x30 in months 0x04, 0x06, 0x09 and 0x11, and after day 0x31 in the other months apart from February. The wrap carries into the month.
- R6: In February, the day wraps after 0x29 when the two-digit year is divisible by four, and after 0x28 in all other years.
- R7: Month counts 0x01 to 0x12 and wraps to 0x01, carrying into the year. The year counts 0x00 to 0x99 and wraps to 0x00.
- R8: The weekday counts 0 to 6 in binary, advances on each day wrap of the hours, and returns to 0 after 6.
- R9: While `run` is 0, ticks change no field and raise no pulse.
- R10: With `run` at 0, a `load` strobe writes all seven load values into the fields in one cycle. With `run` at 1, `load` has no effect.
- R11: `alarm_hit` pulses for one cycle on a tick whose new seconds, minutes, hours, day, month and year all equal the alarm inputs. If any of the six fields differs, no pulse appears, and the weekday is never compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | One-cycle pulse per second |
| run | input | 1 | 1 = count, 0 = frozen and loadable |
| load | input | 1 | Parallel load strobe, acts only while run is 0 |
| ld_sec | input | 8 | Seconds load value, BCD |
| ld_min | input | 8 | Minutes load value, BCD |
| ld_hour | input | 8 | Hours load value, BCD |
| ld_day | input | 8 | Day load value, BCD |
| ld_mon | input | 8 | Month load value, BCD |
| ld_year | input | 8 | Year load value, BCD |
| ld_wday | input | 8 | Weekday load value, 0..6 |
| al_sec | input | 8 | Alarm seconds, BCD |
| al_min | input | 8 | Alarm minutes, BCD |
| al_hour | input | 8 | Alarm hours, BCD |
| al_day | input | 8 | Alarm day, BCD |
| al_mon | input | 8 | Alarm month, BCD |
| al_year | input | 8 | Alarm year, BCD |
| cur_sec | output | 8 | Live seconds |
| cur_min | output | 8 | Live minutes |
| cur_hour | output | 8 | Live hours |
| cur_day | output | 8 | Live day of month |
| cur_mon | output | 8 | Live month |
| cur_year | output | 8 | Live year |
| cur_wday | output | 8 | Live weekday |
| alarm_hit | output | 1 | Alarm match pulse |
| evt_sec | output | 1 | Second boundary pulse |
| evt_min | output | 1 | Minute boundary pulse |
| evt_hour | output | 1 | Hour boundary pulse |
| evt_day | output | 1 | Day boundary pulse |

## Verification
A tick or a load sampled at one rising edge shows up on every field and on every pulse output after that same edge, so the latency is exactly one clock. The internal reset synchronizer only delays the end of reset and adds no latency. The bench drives each one-cycle stimulus on a falling edge, drops it on the next falling edge, and samples the outputs at that moment. That sampling point is half a period after the edge that registered the result and half a period before the pulses clear. The boundary cases use a load to reach the instant just before the rollover under test, so that each month end, leap year and year wrap takes a single tick to check.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int FIELD_W = 8;
  typedef logic [FIELD_W-1:0] bcd8_t;

  // advance a two-digit packed BCD value by one
  function automatic bcd8_t bcd_incr(input bcd8_t v);
    bcd8_t r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction
endpackage

// File: rtl/rtc_bcd_step.sv
module rtc_bcd_step
  import rtc_cal_pkg::*;
#(
  parameter bcd8_t FIRST = 8'h00
) (
  input  bcd8_t cur,
  input  bcd8_t last,
  output bcd8_t nxt,
  output logic  wrap
);
  // a value at or beyond the limit wraps, so out-of-range loads recover
  always_comb begin
    wrap = (cur >= last);
    nxt  = wrap ? FIRST : bcd_incr(cur);
  end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_cal_pkg::*;
(
  input  bcd8_t mon,
  input  bcd8_t year,
  output bcd8_t last_day
);
  logic leap;

  // divisibility by four of a BCD pair: even tens need ones 0/4/8, odd tens need 2/6
  always_comb begin
    if (year[4] == 1'b0)
      leap = (year[3:0] == 4'd0) || (year[3:0] == 4'd4) || (year[3:0] == 4'd8);
    else
      leap = (year[3:0] == 4'd2) || (year[3:0] == 4'd6);
  end

  always_comb begin
    unique case (mon)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_cal_pkg::*;
#(
  parameter int NFIELD = 6
) (
  input  bcd8_t live  [NFIELD],
  input  bcd8_t target[NFIELD],
  output logic  hit
);
  logic [NFIELD-1:0] eq;

  for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
    assign eq[i] = (live[i] == target[i]);
  end

  assign hit = &eq;
endmodule

// File: rtl/bcd_calendar_rtc.sv
module bcd_calendar_rtc
  import rtc_cal_pkg::*;
#(
  parameter int    WEEK_LEN  = 7,
  parameter bcd8_t SEC_LAST  = 8'h59,
  parameter bcd8_t MIN_LAST  = 8'h59,
  parameter bcd8_t HOUR_LAST = 8'h23,
  parameter bcd8_t MON_LAST  = 8'h12,
  parameter bcd8_t YEAR_LAST = 8'h99
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       run,
  input  logic       load,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hour,
  input  logic [7:0] ld_day,
  input  logic [7:0] ld_mon,
  input  logic [7:0] ld_year,
  input  logic [7:0] ld_wday,
  input  logic [7:0] al_sec,
  input  logic [7:0] al_min,
  input  logic [7:0] al_hour,
  input  logic [7:0] al_day,
  input  logic [7:0] al_mon,
  input  logic [7:0] al_year,
  output logic [7:0] cur_sec,
  output logic [7:0] cur_min,
  output logic [7:0] cur_hour,
  output logic [7:0] cur_day,
  output logic [7:0] cur_mon,
  output logic [7:0] cur_year,
  output logic [7:0] cur_wday,
  output logic       alarm_hit,
  output logic       evt_sec,
  output logic       evt_min,
  output logic       evt_hour,
  output logic       evt_day
);
  localparam int    NALARM    = 6;
  localparam bcd8_t WDAY_LAST = bcd8_t'(WEEK_LEN - 1);

  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // state
  bcd8_t sec_q, min_q, hour_q, day_q, mon_q, year_q, wday_q;
  logic  alm_q, es_q, em_q, eh_q, ed_q;

  // next state
  bcd8_t sec_d, min_d, hour_d, day_d, mon_d, year_d, wday_d;
  logic  alm_d, es_d, em_d, eh_d, ed_d;

  // step results
  bcd8_t s_nx, m_nx, h_nx, d_nx, mo_nx, y_nx, day_last;
  logic  s_w, m_w, h_w, d_w, mo_w, y_w;
  logic  adv, c_min, c_hour, c_day, c_mon, c_year, load_ok, match;

  rtc_bcd_step #(.FIRST(8'h00)) u_sec  (.cur(sec_q),  .last(SEC_LAST),  .nxt(s_nx),  .wrap(s_w));
  rtc_bcd_step #(.FIRST(8'h00)) u_min  (.cur(min_q),  .last(MIN_LAST),  .nxt(m_nx),  .wrap(m_w));
  rtc_bcd_step #(.FIRST(8'h00)) u_hour (.cur(hour_q), .last(HOUR_LAST), .nxt(h_nx),  .wrap(h_w));
  rtc_bcd_step #(.FIRST(8'h01)) u_day  (.cur(day_q),  .last(day_last),  .nxt(d_nx),  .wrap(d_w));
  rtc_bcd_step #(.FIRST(8'h01)) u_mon  (.cur(mon_q),  .last(MON_LAST),  .nxt(mo_nx), .wrap(mo_w));
  rtc_bcd_step #(.FIRST(8'h00)) u_year (.cur(year_q), .last(YEAR_LAST), .nxt(y_nx),  .wrap(y_w));

  rtc_month_len u_mlen (.mon(mon_q), .year(year_q), .last_day(day_last));

  // carry chain
  always_comb begin
    adv     = run & tick;
    load_ok = load & ~run;
    c_min   = adv & s_w;
    c_hour  = c_min & m_w;
    c_day   = c_hour & h_w;
    c_mon   = c_day & d_w;
    c_year  = c_mon & mo_w;
  end

  always_comb begin
    if (load_ok) begin
      sec_d  = ld_sec;
      min_d  = ld_min;
      hour_d = ld_hour;
      day_d  = ld_day;
      mon_d  = ld_mon;
      year_d = ld_year;
      wday_d = ld_wday;
    end else begin
      sec_d  = adv    ? s_nx  : sec_q;
      min_d  = c_min  ? m_nx  : min_q;
      hour_d = c_hour ? h_nx  : hour_q;
      day_d  = c_day  ? d_nx  : day_q;
      mon_d  = c_mon  ? mo_nx : mon_q;
      year_d = c_year ? y_nx  : year_q;
      if (c_day) wday_d = (wday_q >= WDAY_LAST) ? 8'h00 : wday_q + 8'h01;
      else       wday_d = wday_q;
    end
  end

  // alarm comparison against the time this tick produces
  bcd8_t live_v [NALARM];
  bcd8_t alrm_v [NALARM];
  always_comb begin
    live_v[0] = sec_d;  alrm_v[0] = al_sec;
    live_v[1] = min_d;  alrm_v[1] = al_min;
    live_v[2] = hour_d; alrm_v[2] = al_hour;
    live_v[3] = day_d;  alrm_v[3] = al_day;
    live_v[4] = mon_d;  alrm_v[4] = al_mon;
    live_v[5] = year_d; alrm_v[5] = al_year;
  end

  rtc_alarm_match #(.NFIELD(NALARM)) u_alm (.live(live_v), .target(alrm_v), .hit(match));

  always_comb begin
    es_d  = adv;
    em_d  = c_min;
    eh_d  = c_hour;
    ed_d  = c_day;
    alm_d = adv & match;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
      day_q  <= 8'h01;
      mon_q  <= 8'h01;
      year_q <= 8'h00;
      wday_q <= 8'h00;
      alm_q  <= 1'b0;
      es_q   <= 1'b0;
      em_q   <= 1'b0;
      eh_q   <= 1'b0;
      ed_q   <= 1'b0;
    end else begin
      sec_q  <= sec_d;
      min_q  <= min_d;
      hour_q <= hour_d;
      day_q  <= day_d;
      mon_q  <= mon_d;
      year_q <= year_d;
      wday_q <= wday_d;
      alm_q  <= alm_d;
      es_q   <= es_d;
      em_q   <= em_d;
      eh_q   <= eh_d;
      ed_q   <= ed_d;
    end
  end

  assign cur_sec   = sec_q;
  assign cur_min   = min_q;
  assign cur_hour  = hour_q;
  assign cur_day   = day_q;
  assign cur_mon   = mon_q;
  assign cur_year  = year_q;
  assign cur_wday  = wday_q;
  assign alarm_hit = alm_q;
  assign evt_sec   = es_q;
  assign evt_min   = em_q;
  assign evt_hour  = eh_q;
  assign evt_day   = ed_q;

  // checks
  AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!run && !load) |=> ($stable(cur_sec) && $stable(cur_min) && $stable(cur_hour) &&
                         $stable(cur_day) && $stable(cur_mon) && $stable(cur_year))); // R9

  AST_SEC_EVT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    evt_sec |-> $past(run && tick)); // R4

  AST_EVT_NESTING: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (evt_min |-> evt_sec) and (evt_hour |-> evt_min) and (evt_day |-> evt_hour)); // R4

  AST_DAY_EVT_MIDNIGHT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    evt_day |-> (cur_hour == 8'h00 && cur_min == 8'h00 && cur_sec == 8'h00)); // R3

  AST_ALARM_FIELDS_EQUAL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    alarm_hit |-> (cur_sec == $past(al_sec) && cur_min == $past(al_min) &&
                   cur_hour == $past(al_hour) && cur_day == $past(al_day) &&
                   cur_mon == $past(al_mon) && cur_year == $past(al_year))); // R11

  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load && !run) |=> (cur_sec == $past(ld_sec) && cur_wday == $past(ld_wday))); // R10
endmodule

// File: tb/bcd_calendar_rtc_test.sv
`timescale 1ns/1ps
module bcd_calendar_rtc_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, run = 1'b0, load = 1'b0;
  logic [7:0] ld_sec = 8'h00, ld_min = 8'h00, ld_hour = 8'h00, ld_day = 8'h01;
  logic [7:0] ld_mon = 8'h01, ld_year = 8'h00, ld_wday = 8'h00;
  logic [7:0] al_sec = 8'hFF, al_min = 8'hFF, al_hour = 8'hFF;
  logic [7:0] al_day = 8'hFF, al_mon = 8'hFF, al_year = 8'hFF;
  logic [7:0] cur_sec, cur_min, cur_hour, cur_day, cur_mon, cur_year, cur_wday;
  logic alarm_hit, evt_sec, evt_min, evt_hour, evt_day;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bcd_calendar_rtc uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .load(load),
    .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_day(ld_day),
    .ld_mon(ld_mon), .ld_year(ld_year), .ld_wday(ld_wday),
    .al_sec(al_sec), .al_min(al_min), .al_hour(al_hour),
    .al_day(al_day), .al_mon(al_mon), .al_year(al_year),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day),
    .cur_mon(cur_mon), .cur_year(cur_year), .cur_wday(cur_wday),
    .alarm_hit(alarm_hit), .evt_sec(evt_sec), .evt_min(evt_min),
    .evt_hour(evt_hour), .evt_day(evt_day)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_time(input string tag, input logic [7:0] s, mi, h, d, mo, y, w);
    chk(tag, {cur_sec, cur_min, cur_hour, cur_day, cur_mon, cur_year, cur_wday},
        {s, mi, h, d, mo, y, w});
  endtask

  task automatic chk_evt(input string tag, input logic [4:0] exp);
    chk(tag, {alarm_hit, evt_sec, evt_min, evt_hour, evt_day}, exp);
  endtask

  // stop, load all fields in one cycle, restart
  task automatic set_time(input logic [7:0] s, mi, h, d, mo, y, w);
    @(negedge clk);
    run = 1'b0; load = 1'b1;
    ld_sec = s; ld_min = mi; ld_hour = h; ld_day = d;
    ld_mon = mo; ld_year = y; ld_wday = w;
    @(negedge clk);
    load = 1'b0; run = 1'b1;
  endtask

  task automatic one_tick;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic t_reset;
    chk_time("R1 reset fields", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00);
    chk_evt("R1 reset pulses", 5'b00000);
  endtask

  task automatic t_seconds;
    set_time(8'h08, 8'h10, 8'h05, 8'h03, 8'h07, 8'h21, 8'h02);
    chk_time("R10 load all fields", 8'h08, 8'h10, 8'h05, 8'h03, 8'h07, 8'h21, 8'h02);
    one_tick;
    chk_time("R2 08->09", 8'h09, 8'h10, 8'h05, 8'h03, 8'h07, 8'h21, 8'h02);
    chk_evt("R4 second pulse only", 5'b01000);
    one_tick;
    chk_time("R2 decimal carry 09->10", 8'h10, 8'h10, 8'h05, 8'h03, 8'h07, 8'h21, 8'h02);
    @(negedge clk);
    chk_evt("R4 pulse lasts one cycle", 5'b00000);
  endtask

  task automatic t_minute_hour;
    set_time(8'h59, 8'h41, 8'h07, 8'h12, 8'h03, 8'h30, 8'h04);
    one_tick;
    chk_time("R3 seconds wrap", 8'h00, 8'h42, 8'h07, 8'h12, 8'h03, 8'h30, 8'h04);
    chk_evt("R4 minute pulse", 5'b01100);
    set_time(8'h59, 8'h59, 8'h09, 8'h12, 8'h03, 8'h30, 8'h04);
    one_tick;
    chk_time("R3 minute wrap", 8'h00, 8'h00, 8'h10, 8'h12, 8'h03, 8'h30, 8'h04);
    chk_evt("R4 hour pulse", 5'b01110);
  endtask

  task automatic t_day_week;
    set_time(8'h59, 8'h59, 8'h23, 8'h15, 8'h08, 8'h40, 8'h06);
    one_tick;
    chk_time("R3 R8 hour wrap, weekday 6->0", 8'h00, 8'h00, 8'h00, 8'h16, 8'h08, 8'h40, 8'h00);
    chk_evt("R4 day pulse", 5'b01111);
    set_time(8'h59, 8'h59, 8'h23, 8'h16, 8'h08, 8'h40, 8'h02);
    one_tick;
    chk("R8 weekday 2->3", cur_wday, 8'h03);
  endtask

  task automatic t_months;
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h15, 8'h01);
    one_tick;
    chk_time("R5 30-day month end", 8'h00, 8'h00, 8'h00, 8'h01, 8'h05, 8'h15, 8'h02);
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h01, 8'h15, 8'h01);
    one_tick;
    chk("R5 day 30 in 31-day month", {cur_day, cur_mon}, 16'h3101);
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h01, 8'h15, 8'h01);
    one_tick;
    chk("R5 31-day month end", {cur_day, cur_mon}, 16'h0102);
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23, 8'h01);
    one_tick;
    chk("R6 Feb 28 common year", {cur_day, cur_mon}, 16'h0103);
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 8'h01);
    one_tick;
    chk("R6 Feb 28 leap year 24", {cur_day, cur_mon}, 16'h2902);
    one_tick;
    chk("R6 tick after Feb 28 rollover", {cur_day, cur_sec}, 16'h2901);
    set_time(8'h59, 8'h59, 8'h23, 8'h29, 8'h02, 8'h96, 8'h01);
    one_tick;
    chk("R6 Feb 29 leap year 96", {cur_day, cur_mon}, 16'h0103);
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h10, 8'h01);
    one_tick;
    chk("R6 year 10 not leap", {cur_day, cur_mon}, 16'h0103);
  endtask

  task automatic t_year;
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h49, 8'h05);
    one_tick;
    chk("R7 Dec to Jan carries year", {cur_day, cur_mon, cur_year}, 24'h010150);
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h05);
    one_tick;
    chk_time("R7 year 99 wraps", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h06);
  endtask

  task automatic t_stop;
    set_time(8'h20, 8'h20, 8'h20, 8'h20, 8'h06, 8'h20, 8'h03);
    @(negedge clk); run = 1'b0;
    one_tick;
    chk_time("R9 frozen while stopped", 8'h20, 8'h20, 8'h20, 8'h20, 8'h06, 8'h20, 8'h03);
    chk_evt("R9 no pulse while stopped", 5'b00000);
    @(negedge clk); run = 1'b1; load = 1'b1;
    ld_sec = 8'h44; ld_min = 8'h44; ld_hour = 8'h11; ld_day = 8'h11;
    ld_mon = 8'h11; ld_year = 8'h11; ld_wday = 8'h05;
    @(negedge clk); load = 1'b0;
    chk_time("R10 load ignored while running", 8'h20, 8'h20, 8'h20, 8'h20, 8'h06, 8'h20, 8'h03);
  endtask

  task automatic t_alarm;
    al_sec = 8'h32; al_min = 8'h15; al_hour = 8'h08;
    al_day = 8'h09; al_mon = 8'h10; al_year = 8'h33;
    set_time(8'h30, 8'h15, 8'h08, 8'h09, 8'h10, 8'h33, 8'h01);
    one_tick;
    chk("R11 no alarm before match", alarm_hit, 1'b0);
    one_tick;
    chk("R11 alarm on matching tick", alarm_hit, 1'b1);
    @(negedge clk);
    chk("R11 alarm one cycle", alarm_hit, 1'b0);
    one_tick;
    chk("R11 no alarm after match", alarm_hit, 1'b0);
    al_day = 8'h10;
    set_time(8'h31, 8'h15, 8'h08, 8'h09, 8'h10, 8'h33, 8'h01);
    one_tick;
    chk("R11 day differs, no alarm", alarm_hit, 1'b0);
    al_day = 8'h09;
    set_time(8'h31, 8'h15, 8'h08, 8'h09, 8'h10, 8'h33, 8'h06);
    one_tick;
    chk("R11 weekday ignored", alarm_hit, 1'b1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_seconds;
    t_minute_hour;
    t_day_week;
    t_months;
    t_year;
    t_stop;
    t_alarm;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end
endmodule